// File: doc/BRIEF.md
# Request-Driven Serial Word Streamer

This block hands 16-bit text words to a host over a single data line, one bit per clock, for as long as the host holds its request line high. Words arrive from an on-chip word source through a valid/ready handshake. A word is accepted only when the previous one has been fully shifted out, most significant bit first.

Two clocking schemes are supported, and a static configuration input selects between them. In external-clock mode the host supplies the bit clock. That clock is brought into the system clock domain through a synchronizer, and a second configuration input states whether the clock idles low or idles high. The data line then moves on the edge that leaves the idle level, so the host samples on the edge that returns to it. In internal-clock mode the block makes the bit clock itself, with a half period of a parameterized number of system cycles. The clock rests high and the data line moves on its falling edge. The clock only starts after a fixed window of generated clock periods following the request, and it keeps that same window after the request is withdrawn.

Top module: `hs_text_serout`

## Requirements
- R1: After reset, `sck_out` is high, `sdo_out` is low and `word_ready` is low.
- R2: Each accepted word appears on `sdo_out` as exactly 16 bits, most significant bit first, and words follow one another in the order the source delivered them.
- R3: `word_ready` is high only while the synchronized request is high and no word is being shifted. A new word is taken only after the 16th bit of the previous word has been launched.
- R4: External mode with `cfg_ext_idle_high`=0: `sdo_out` takes the next bit a few system cycles after a rising edge of `ext_sck_in` and holds it across the following falling edge.
- R5: External mode with `cfg_ext_idle_high`=1: `sdo_out` takes the next bit after a falling edge of `ext_sck_in` and holds it across the following rising edge.
- R6: Internal mode (`cfg_int_clk`=1): `sck_out` rests high and `sdo_out` changes on its falling edge. One bit period is 2*HALF_DIV system cycles while words keep coming.
- R7: Internal mode: the first falling edge of `sck_out` comes no earlier than LAT_PERIODS*2*HALF_DIV system cycles after `req_in` rises, and no later than that plus HALF_DIV plus a few synchronizer cycles.
- R8: After `req_in` falls, no further word is taken. The word in flight is completed, and `sck_out` makes no falling edge later than LAT_PERIODS*2*HALF_DIV cycles after the fall, ending high.
- R9: Internal mode with the source empty: `sck_out` is held high and no bit is launched until a word becomes available. Streaming then resumes.
- R10: External mode with the request low: edges on `ext_sck_in` neither change `sdo_out` nor take a word from the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_int_clk | input | 1 | 1 = internally generated bit clock, 0 = host-supplied bit clock |
| cfg_ext_idle_high | input | 1 | Idle level of the host-supplied clock (1 = high) |
| req_in | input | 1 | Host transfer request, asynchronous |
| ext_sck_in | input | 1 | Host-supplied bit clock, asynchronous |
| word_data | input | WORD_W | Word offered by the source |
| word_valid | input | 1 | Source has a word |
| word_ready | output | 1 | Block accepts the offered word this cycle |
| sck_out | output | 1 | Generated bit clock (high when unused) |
| sdo_out | output | 1 | Serial data to the host |

## Verification
The bench goes after the window boundaries of internal mode. A miscounted start delay shows up as a first falling edge outside the allowed band. A generator that ignores the stop window either keeps clocking or cuts the word in flight, and the received words then fail to match the expected ones. A dropped request in the middle of a word is checked for over-fetch: a design that takes the next word anyway leaves the source one word short. An empty source is checked for a clock that keeps toggling, and each external polarity is checked for data that moves on the sampling edge instead of the launch edge. Clock edges with the request low are checked for any word consumed or any data-line change.

// File: rtl/hs_text_pkg.sv
package hs_text_pkg;
   typedef enum logic {
      CLK_SRC_EXT = 1'b0,
      CLK_SRC_INT = 1'b1
   } clk_src_e;

   function automatic clk_src_e decode_src(input logic sel);
      return sel ? CLK_SRC_INT : CLK_SRC_EXT;
   endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("hs_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hs_ext_edge.sv
module hs_ext_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic idle_high,
   output logic launch_edge
);
   logic prev;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sck_s;
   end

   assign rise        = sck_s & ~prev;
   assign fall        = ~sck_s & prev;
   // launch on the edge leaving the idle level
   assign launch_edge = idle_high ? fall : rise;
endmodule

// File: rtl/hs_clk_gen.sv
module hs_clk_gen #(
   parameter int HALF_DIV    = 16,
   parameter int LAT_PERIODS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic req_s,
   input  logic busy,
   output logic sck,
   output logic launch
);
   localparam int LIMIT = LAT_PERIODS * 2 * HALF_DIV;
   localparam int LCW   = $clog2(LIMIT + 1);
   localparam int HCW   = $clog2(HALF_DIV + 1);

   generate
      if (HALF_DIV < 2)    begin : g_bad_div $error("HALF_DIV must be >= 2"); end
      if (LAT_PERIODS < 1) begin : g_bad_lat $error("LAT_PERIODS must be >= 1"); end
   endgenerate

   logic [LCW-1:0] win_cnt;
   logic           active;
   logic [HCW-1:0] half_cnt;
   logic           sck_q;
   logic           half_done;

   // start/stop window: active follows req_s after LIMIT cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         active  <= 1'b0;
      end else if (!en) begin
         win_cnt <= '0;
         active  <= 1'b0;
      end else if (req_s != active) begin
         if (win_cnt == LCW'(LIMIT - 1)) begin
            win_cnt <= '0;
            active  <= req_s;
         end else begin
            win_cnt <= win_cnt + 1'b1;
         end
      end else begin
         win_cnt <= '0;
      end
   end

   assign half_done = (half_cnt == HCW'(HALF_DIV - 1));
   assign launch    = en & sck_q & active & busy & half_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b1;
         half_cnt <= '0;
      end else if (!en) begin
         sck_q    <= 1'b1;
         half_cnt <= '0;
      end else if (sck_q) begin
         if (active && busy) begin
            if (half_done) begin
               sck_q    <= 1'b0;
               half_cnt <= '0;
            end else begin
               half_cnt <= half_cnt + 1'b1;
            end
         end else begin
            half_cnt <= '0;
         end
      end else begin
         if (half_done) begin
            sck_q    <= 1'b1;
            half_cnt <= '0;
         end else begin
            half_cnt <= half_cnt + 1'b1;
         end
      end
   end

   assign sck = sck_q;

   // R9: with nothing to send the clock rests high
   a_r9_hold_high_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sck_q && !busy) |=> sck_q);

   // R7/R8: no clock activity outside the start/stop window
   a_r7_no_edge_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q && !active) |=> sck_q);
endmodule

// File: rtl/hs_word_shifter.sv
module hs_word_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fetch_en,
   input  logic         launch,
   input  logic [W-1:0] word_data,
   input  logic         word_valid,
   output logic         word_ready,
   output logic         loaded,
   output logic         sdo
);
   localparam int CW = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w $error("word width must be >= 2"); end
   endgenerate

   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          loaded_q;
   logic          sdo_q;

   assign word_ready = fetch_en & ~loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         cnt      <= '0;
         loaded_q <= 1'b0;
         sdo_q    <= 1'b0;
      end else if (word_ready && word_valid) begin
         sh       <= word_data;
         cnt      <= '0;
         loaded_q <= 1'b1;
      end else if (launch && loaded_q) begin
         sdo_q <= sh[W-1];
         sh    <= {sh[W-2:0], 1'b0};
         if (cnt == CW'(W - 1)) begin
            cnt      <= '0;
            loaded_q <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign loaded = loaded_q;
   assign sdo    = sdo_q;

   // R3: a taken word starts fresh at its MSB
   a_r3_fetch_starts_at_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ready && word_valid) |=> (loaded_q && cnt == '0 && sh == $past(word_data)));

   // R2: the last bit of a word frees the shifter
   a_r2_word_ends_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && loaded_q && cnt == CW'(W - 1)) |=> !loaded_q);
endmodule

// File: rtl/hs_text_serout.sv
module hs_text_serout
   import hs_text_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int HALF_DIV    = 16,
   parameter int LAT_PERIODS = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_int_clk,
   input  logic              cfg_ext_idle_high,
   input  logic              req_in,
   input  logic              ext_sck_in,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_valid,
   output logic              word_ready,
   output logic              sck_out,
   output logic              sdo_out
);
   clk_src_e src;
   logic     req_s, ext_s;
   logic     ext_launch, gen_launch, launch;
   logic     loaded;
   logic     int_en;

   assign src    = decode_src(cfg_int_clk);
   assign int_en = (src == CLK_SRC_INT);

   hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d_async(req_in), .q_sync(req_s));

   hs_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d_async(ext_sck_in), .q_sync(ext_s));

   hs_ext_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sck_s(ext_s),
      .idle_high(cfg_ext_idle_high), .launch_edge(ext_launch));

   hs_clk_gen #(.HALF_DIV(HALF_DIV), .LAT_PERIODS(LAT_PERIODS)) u_gen (
      .clk(clk), .rst_n(rst_n), .en(int_en), .req_s(req_s),
      .busy(loaded), .sck(sck_out), .launch(gen_launch));

   assign launch = int_en ? gen_launch : (ext_launch & req_s);

   hs_word_shifter #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .fetch_en(req_s), .launch(launch),
      .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
      .loaded(loaded), .sdo(sdo_out));

   // R10: host edges without a request leave the data line alone
   a_r10_ext_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en && !req_s) |=> $stable(sdo_out));

   // R3: no word is taken while the request is low
   a_r3_no_fetch_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      !req_s |-> !word_ready);
endmodule

// File: tb/hs_text_serout_test.sv
module hs_text_serout_test;
   localparam int HALF  = 16;
   localparam int LAT   = 32;
   localparam int LIMIT = LAT * 2 * HALF;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        cfg_int_clk = 1'b1, cfg_ext_idle_high = 1'b0;
   logic        req_in = 1'b0, ext_sck_in = 1'b0;
   logic [15:0] word_data = '0;
   logic        word_valid = 1'b0;
   logic        word_ready, sck_out, sdo_out;

   hs_text_serout #(.WORD_W(16), .HALF_DIV(HALF), .LAT_PERIODS(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_int_clk(cfg_int_clk),
      .cfg_ext_idle_high(cfg_ext_idle_high), .req_in(req_in),
      .ext_sck_in(ext_sck_in), .word_data(word_data), .word_valid(word_valid),
      .word_ready(word_ready), .sck_out(sck_out), .sdo_out(sdo_out));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [15:0] src_q[$];
   logic [15:0] exp_q[$];
   int n_checks = 0, n_fail = 0;
   int words_rx = 0, rx_n = 0;
   logic [15:0] rx_sh = '0;
   int fall_cnt = 0, first_fall = 0, second_fall = 0, last_fall = 0;
   logic prev_sck = 1'b1;
   bit done = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", rq, got, exp);
      end
   endtask

   task automatic refresh();
      word_valid = (src_q.size() != 0);
      word_data  = word_valid ? src_q[0] : 16'h0;
   endtask

   task automatic push(input logic [15:0] w);
      src_q.push_back(w);
      exp_q.push_back(w);
      refresh();
   endtask

   // scoreboard compare for every completed word
   task automatic take_bit(input logic b);
      logic [15:0] e;
      rx_sh = {rx_sh[14:0], b};
      rx_n++;
      if (rx_n == 16) begin
         rx_n = 0;
         words_rx++;
         if (exp_q.size() == 0) chk(1'b0, "R2", rx_sh, 32'hdead);
         else begin
            e = exp_q.pop_front();
            chk(rx_sh == e, "R2", rx_sh, e);
         end
      end
   endtask

   // word source model
   initial begin
      forever begin
         @(negedge clk);
         if (word_ready && word_valid) begin
            @(posedge clk);
            #1;
            void'(src_q.pop_front());
            refresh();
         end
      end
   end

   // monitor for the generated clock: host samples on rising sck_out
   always @(negedge clk) begin
      if (rst_n) begin
         if (!prev_sck && sck_out) take_bit(sdo_out);
         if (prev_sck && !sck_out) begin
            fall_cnt++;
            last_fall = cyc;
            if (fall_cnt == 1) first_fall = cyc;
            if (fall_cnt == 2) second_fall = cyc;
         end
      end
      prev_sck = sck_out;
   end

   // one host-clocked bit: launch edge, read, sampling edge, hold check
   task automatic ext_bit(input logic idle, input string rq);
      logic b;
      ext_sck_in = ~idle;
      repeat (10) @(negedge clk);
      b = sdo_out;
      ext_sck_in = idle;
      repeat (6) @(negedge clk);
      chk(sdo_out == b, rq, sdo_out, b);
      repeat (4) @(negedge clk);
      take_bit(b);
   endtask

   task automatic wait_words(input int n);
      for (int i = 0; i < 20000 && words_rx < n; i++) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got %0d expected done", cyc);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int t0, t1, f, s;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sck_out == 1'b1, "R1", sck_out, 1);
      chk(sdo_out == 1'b0, "R1", sdo_out, 0);
      chk(word_ready == 1'b0, "R1", word_ready, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // internal mode: latency, bit period, MSB-first words (R2 R6 R7)
      cfg_int_clk = 1'b1;
      push(16'hA5C3); push(16'h8001); push(16'h7FFE);
      fall_cnt = 0;
      req_in = 1'b1;
      t0 = cyc;
      wait_words(3);
      chk((first_fall - t0) >= LIMIT && (first_fall - t0) <= LIMIT + HALF + 6,
          "R7", first_fall - t0, LIMIT);
      chk(second_fall - first_fall == 2 * HALF, "R6", second_fall - first_fall, 2 * HALF);
      chk(exp_q.size() == 0, "R2", exp_q.size(), 0);

      // R9: empty source holds the clock high, then resumes
      repeat (4) @(negedge clk);
      f = fall_cnt;
      repeat (400) @(negedge clk);
      chk(fall_cnt == f, "R9", fall_cnt, f);
      chk(sck_out == 1'b1, "R9", sck_out, 1);
      push(16'h1234);
      wait_words(4);
      chk(words_rx == 4, "R9", words_rx, 4);

      // R8: request withdrawn mid-word
      push(16'hC0DE); push(16'hBEEF); push(16'h0F0F); push(16'hF00D);
      wait_words(5);
      repeat (10 * HALF) @(negedge clk);
      req_in = 1'b0;
      t1 = cyc;
      repeat (LIMIT + HALF + 60) @(negedge clk);
      chk(words_rx == 6, "R8", words_rx, 6);
      chk(src_q.size() == 2, "R8", src_q.size(), 2);
      chk(last_fall - t1 <= LIMIT, "R8", last_fall - t1, LIMIT);
      chk(sck_out == 1'b1, "R8", sck_out, 1);
      void'(exp_q.pop_back()); void'(exp_q.pop_back());
      src_q.delete();
      refresh();

      // R4: host clock idling low
      cfg_int_clk = 1'b0; cfg_ext_idle_high = 1'b0; ext_sck_in = 1'b0;
      repeat (5) @(negedge clk);
      push(16'h9A3C); push(16'h0001);
      req_in = 1'b1;
      repeat (10) @(negedge clk);
      for (int i = 0; i < 32; i++) ext_bit(1'b0, "R4");
      chk(words_rx == 8, "R4", words_rx, 8);
      req_in = 1'b0;
      repeat (5) @(negedge clk);

      // R5: host clock idling high
      ext_sck_in = 1'b1;
      repeat (5) @(negedge clk);
      cfg_ext_idle_high = 1'b1;
      repeat (5) @(negedge clk);
      push(16'h5AA5); push(16'hE718);
      req_in = 1'b1;
      repeat (10) @(negedge clk);
      for (int i = 0; i < 32; i++) ext_bit(1'b1, "R5");
      chk(words_rx == 10, "R5", words_rx, 10);
      req_in = 1'b0;
      repeat (5) @(negedge clk);

      // R10: host clocking without request
      push(16'h3C96);
      s = sdo_out;
      for (int i = 0; i < 20; i++) begin
         ext_sck_in = 1'b0; repeat (10) @(negedge clk);
         ext_sck_in = 1'b1; repeat (10) @(negedge clk);
      end
      chk(src_q.size() == 1, "R10", src_q.size(), 1);
      chk(sdo_out == s[0], "R10", sdo_out, s);
      chk(words_rx == 10, "R10", words_rx, 10);
      req_in = 1'b1;
      repeat (10) @(negedge clk);
      for (int i = 0; i < 16; i++) ext_bit(1'b1, "R5");
      chk(words_rx == 11, "R10", words_rx, 11);
      chk(exp_q.size() == 0, "R2", exp_q.size(), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule